// File: doc/BRIEF.md
# Windowed Register Address Remapper

This block sits on the device side of a host register bus and lets a host with a 1 MB view reach a 32 MB internal register and memory space. The host aperture has two halves. Offsets in the lower 512 KB go straight to the same internal addresses. Offsets in the upper 512 KB are redirected into one 512 KB slice of the internal space. A control register held inside the block selects that slice.

The control register lives at a fixed offset in the lower half. It holds an enable flag and a 6-bit slice number. The host writes it to move the window and can read it back to confirm the change before it uses the new window.

The host port takes one access at a time through a valid/ready handshake and returns a one-cycle response. Accesses that reach the internal space go out on a simple master port. That port holds each request until the internal side signals completion.

Top module: `win_remap`

## Requirements
- R1: A host access at an offset below 0x80000, other than the control register, is issued on the internal port at the same address, whatever the window setting or enable flag.
- R2: A host access at an offset from 0x80000 to 0xFFFFF, with the enable flag set, is issued on the internal port at address {index, offset[18:0]}. Each index therefore selects a 512 KB slice, and 64 slices cover 25 address bits.
- R3: The control register is decoded at host offset 0x0310C. Accesses to it are served inside the block and never appear on the internal port. A write takes the index from write-data bits [5:0] and the enable flag from bit ENABLE_BIT (31 by default; 30 is the alternative).
- R4: A read of the control register returns the index and the enable flag in the same bit positions they were written to, with every other bit zero. The `winCtrl` output always shows this same value.
- R5: After reset, `winCtrl` is 0, `hostReady` is 1, and `hostRspValid` and `memValid` are 0.
- R6: While the enable flag is clear, upper-half accesses do not reach the internal port. Reads return 0xDEADBEEF and writes are discarded.
- R7: A control register write applies to the very next host access. The window never changes while an internal access is outstanding.
- R8: `hostReady` is high only when no access is in progress. `memValid` stays high with a stable address, data and direction until `memReady`, for any number of wait cycles.
- R9: Every accepted access gets exactly one cycle of `hostRspValid`. For a read that goes to the internal port, `hostRdata` carries the `memRdata` value captured when `memReady` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostValid | input | 1 | Host request valid |
| hostReady | output | 1 | Block can accept a request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 20 | Host byte offset inside the aperture |
| hostWdata | input | 32 | Host write data |
| hostRspValid | output | 1 | One-cycle response pulse |
| hostRdata | output | 32 | Read data, valid with the response |
| memValid | output | 1 | Internal request valid |
| memReady | input | 1 | Internal access completes this cycle |
| memWrite | output | 1 | Internal direction, 1 = write |
| memAddr | output | 25 | Internal byte address |
| memWdata | output | 32 | Internal write data |
| memRdata | input | 32 | Internal read data, sampled with memReady |
| winCtrl | output | 32 | Current control register value |

## Verification
The assertions assume that the internal side raises `memReady` only while `memValid` is high. They also assume the host holds `hostValid` for one cycle, and only when `hostReady` is high.

The bench's memory model answers only outstanding requests, sometimes after several wait cycles. Its host task drives a request only after it has seen `hostReady` high and drops `hostValid` after one cycle. Read data from the model is a function of the address, so each read also confirms the address that was translated.

// File: rtl/win_remap_pkg.sv
package win_remap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_LOCAL = 2'd2,
    ST_RESP  = 2'd3
  } remapState_t;

  typedef enum logic [1:0] {
    KIND_BUS   = 2'd0,
    KIND_REG   = 2'd1,
    KIND_BLOCK = 2'd2
  } accessKind_t;

  typedef struct packed {
    logic accept;    // latch the host request
    logic winWrite;  // update the window register from latched data
    logic capMem;    // capture internal read data
    logic capReg;    // capture control register readback
    logic capBlock;  // capture the fill pattern for a blocked read
  } remapStb_t;

endpackage

// File: rtl/win_remap_ctrl.sv
module win_remap_ctrl
  import win_remap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostValid,
  input  logic      hostWrite,
  input  logic      hitCtrl,
  input  logic      blocked,
  input  logic      memReady,
  output logic      hostReady,
  output logic      hostRspValid,
  output logic      memValid,
  output remapStb_t stb
);

  remapState_t state, stateNext;
  accessKind_t kind;
  logic        kindWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= KIND_BUS;
      kindWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.accept) begin
        kindWrite <= hostWrite;
        if (hitCtrl)      kind <= KIND_REG;
        else if (blocked) kind <= KIND_BLOCK;
        else              kind <= KIND_BUS;
      end
    end
  end

  always_comb begin
    stateNext    = state;
    stb          = '0;
    hostReady    = 1'b0;
    hostRspValid = 1'b0;
    memValid     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        hostReady = 1'b1;
        if (hostValid) begin
          stb.accept = 1'b1;
          stateNext  = (hitCtrl || blocked) ? ST_LOCAL : ST_BUS;
        end
      end
      ST_BUS: begin
        memValid = 1'b1;
        if (memReady) begin
          stb.capMem = !kindWrite;
          stateNext  = ST_RESP;
        end
      end
      ST_LOCAL: begin
        if (kind == KIND_REG) begin
          stb.winWrite = kindWrite;
          stb.capReg   = !kindWrite;
        end else begin
          stb.capBlock = !kindWrite;
        end
        stateNext = ST_RESP;
      end
      ST_RESP: begin
        hostRspValid = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRspValid |=> !hostRspValid);

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || hostRspValid) |-> !hostReady);

endmodule

// File: rtl/win_remap_dp.sv
module win_remap_dp
  import win_remap_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WIN_SHIFT  = 19,
  parameter int IDX_W      = 6,
  parameter int ENABLE_BIT = 31,
  parameter logic [WIN_SHIFT:0] CTRL_OFFSET = 20'h0310C,
  parameter logic [DW-1:0]      BLOCK_DATA  = 32'hDEADBEEF,
  localparam int HOST_AW = WIN_SHIFT + 1,
  localparam int INT_AW  = WIN_SHIFT + IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  remapStb_t          stb,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  input  logic [DW-1:0]      memRdata,
  output logic               hitCtrl,
  output logic               blocked,
  output logic               reqHigh,
  output logic [DW-1:0]      hostRdata,
  output logic               memWrite,
  output logic [INT_AW-1:0]  memAddr,
  output logic [DW-1:0]      memWdata,
  output logic [DW-1:0]      winCtrl
);

  logic [IDX_W-1:0]  winIdx;
  logic              winEn;
  logic              isHigh;
  logic [INT_AW-1:0] mappedAddr;

  assign isHigh  = hostAddr[HOST_AW-1];
  assign hitCtrl = (hostAddr == CTRL_OFFSET);
  assign blocked = isHigh && !winEn;

  always_comb begin
    if (isHigh) mappedAddr = {winIdx, hostAddr[WIN_SHIFT-1:0]};
    else        mappedAddr = {{IDX_W{1'b0}}, hostAddr[WIN_SHIFT-1:0]};
  end

  always_comb begin
    winCtrl                = '0;
    winCtrl[IDX_W-1:0]     = winIdx;
    winCtrl[ENABLE_BIT]    = winEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWdata <= '0;
      memWrite <= 1'b0;
      reqHigh  <= 1'b0;
    end else if (stb.accept) begin
      memAddr  <= mappedAddr;
      memWdata <= hostWdata;
      memWrite <= hostWrite;
      reqHigh  <= isHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winIdx <= '0;
      winEn  <= 1'b0;
    end else if (stb.winWrite) begin
      winIdx <= memWdata[IDX_W-1:0];
      winEn  <= memWdata[ENABLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             hostRdata <= '0;
    else if (stb.capMem)   hostRdata <= memRdata;
    else if (stb.capReg)   hostRdata <= winCtrl;
    else if (stb.capBlock) hostRdata <= BLOCK_DATA;
  end

  // R4
  ctrl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capReg |=> ($countones(hostRdata) <= IDX_W + 1));

endmodule

// File: rtl/win_remap.sv
module win_remap
  import win_remap_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WIN_SHIFT  = 19,
  parameter int IDX_W      = 6,
  parameter int ENABLE_BIT = 31,
  parameter logic [WIN_SHIFT:0] CTRL_OFFSET = 20'h0310C,
  parameter logic [DW-1:0]      BLOCK_DATA  = 32'hDEADBEEF,
  localparam int HOST_AW = WIN_SHIFT + 1,
  localparam int INT_AW  = WIN_SHIFT + IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  output logic               hostReady,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  output logic               hostRspValid,
  output logic [DW-1:0]      hostRdata,
  output logic               memValid,
  input  logic               memReady,
  output logic               memWrite,
  output logic [INT_AW-1:0]  memAddr,
  output logic [DW-1:0]      memWdata,
  input  logic [DW-1:0]      memRdata,
  output logic [DW-1:0]      winCtrl
);

  remapStb_t stb;
  logic      hitCtrl;
  logic      blocked;
  logic      reqHigh;

  win_remap_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostValid    (hostValid),
    .hostWrite    (hostWrite),
    .hitCtrl      (hitCtrl),
    .blocked      (blocked),
    .memReady     (memReady),
    .hostReady    (hostReady),
    .hostRspValid (hostRspValid),
    .memValid     (memValid),
    .stb          (stb)
  );

  win_remap_dp #(
    .DW          (DW),
    .WIN_SHIFT   (WIN_SHIFT),
    .IDX_W       (IDX_W),
    .ENABLE_BIT  (ENABLE_BIT),
    .CTRL_OFFSET (CTRL_OFFSET),
    .BLOCK_DATA  (BLOCK_DATA)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .memRdata  (memRdata),
    .hitCtrl   (hitCtrl),
    .blocked   (blocked),
    .reqHigh   (reqHigh),
    .hostRdata (hostRdata),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .winCtrl   (winCtrl)
  );

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) &&
                                 $stable(memWdata) && $stable(memWrite)));

  // R6
  blocked_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && reqHigh) |-> winCtrl[ENABLE_BIT]);

  // R7
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |=> $stable(winCtrl));

  // R5
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_idle_chk: assert (!memValid && !hostRspValid);
    end
  end

endmodule

// File: tb/sim_win_remap.sv
`timescale 1ns/1ps
module sim_win_remap;

  localparam int EN = 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostReady;
  logic        hostWrite = 1'b0;
  logic [19:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostRspValid;
  logic [31:0] hostRdata;
  logic        memValid;
  logic        memReady = 1'b0;
  logic        memWrite;
  logic [24:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic [31:0] winCtrl;

  int errors = 0;
  int checks = 0;
  int memLat = 0;
  int txnCount = 0;
  logic [24:0] lastAddr = '0;
  logic [31:0] lastWdata = '0;
  logic        lastWr = 1'b0;

  always #10 clk = ~clk;

  win_remap u0 (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostReady(hostReady), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRspValid(hostRspValid), .hostRdata(hostRdata),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .winCtrl(winCtrl)
  );

  function automatic logic [31:0] pat(input logic [24:0] a);
    return {7'd0, a} ^ 32'h5A5A0000;
  endfunction

  // internal memory model, answers after memLat wait cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memValid && !memReady) begin
        if (waitCnt < memLat) waitCnt++;
        else begin
          memReady  = 1'b1;
          memRdata  = pat(memAddr);
          lastAddr  = memAddr;
          lastWdata = memWdata;
          lastWr    = memWrite;
          txnCount++;
          waitCnt   = 0;
        end
      end else begin
        memReady = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [19:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    int guard = 0;
    @(negedge clk);
    while (!hostReady && guard < 100) begin @(negedge clk); guard++; end
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0;
    guard = 0;
    while (!hostRspValid && guard < 100) begin @(negedge clk); guard++; end
    rd = hostRdata;
    chk(hostRspValid, "R9 response seen", {31'd0, hostRspValid}, 32'd1);
    @(negedge clk);
    chk(!hostRspValid, "R9 single-cycle response", {31'd0, hostRspValid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(winCtrl == 0, "R5 winCtrl reset", winCtrl, 0);
    chk(hostReady && !hostRspValid && !memValid, "R5 idle outputs",
        {29'd0, hostReady, hostRspValid, memValid}, 32'h4);
  endtask

  task automatic t_low();
    logic [31:0] rd;
    int n0 = txnCount;
    access(0, 20'h00124, 0, rd);
    chk(rd == pat(25'h00124), "R1 low read data", rd, pat(25'h00124));
    access(1, 20'h7FFFC, 32'h1234ABCD, rd);
    chk(lastAddr == 25'h7FFFC && lastWr, "R1 low write address", {7'd0, lastAddr}, 32'h7FFFC);
    chk(lastWdata == 32'h1234ABCD, "R1 low write data", lastWdata, 32'h1234ABCD);
    chk(txnCount == n0 + 2, "R1 two internal accesses", txnCount, n0 + 2);
  endtask

  task automatic t_disabled(input string tag);
    logic [31:0] rd;
    int n0 = txnCount;
    access(0, 20'h80010, 0, rd);
    chk(rd == 32'hDEADBEEF, {tag, " blocked read pattern"}, rd, 32'hDEADBEEF);
    access(1, 20'hC0000, 32'h55, rd);
    chk(txnCount == n0, {tag, " no internal access"}, txnCount, n0);
  endtask

  task automatic t_ctrl();
    logic [31:0] rd;
    int n0 = txnCount;
    access(1, 20'h0310C, 32'h80FF0005, rd);
    access(0, 20'h0310C, 0, rd);
    chk(rd == 32'h80000005, "R4 readback", rd, 32'h80000005);
    chk(winCtrl == 32'h80000005, "R4 winCtrl output", winCtrl, 32'h80000005);
    chk(txnCount == n0, "R3 control not forwarded", txnCount, n0);
  endtask

  task automatic t_high();
    logic [31:0] rd;
    access(0, 20'h80040, 0, rd);
    chk(rd == pat(25'h0280040), "R2 high read index 5", rd, pat(25'h0280040));
    access(1, 20'hFFFFC, 32'hCAFE0001, rd);
    chk(lastAddr == 25'h02FFFFC, "R2 high write address", {7'd0, lastAddr}, 32'h02FFFFC);
    chk(lastWdata == 32'hCAFE0001, "R2 high write data", lastWdata, 32'hCAFE0001);
  endtask

  task automatic t_switch();
    logic [31:0] rd;
    access(1, 20'h0310C, 32'h8000003F, rd);
    access(0, 20'h80000, 0, rd);
    chk(rd == pat(25'h1F80000), "R7 next access uses new window", rd, pat(25'h1F80000));
    access(0, 20'h00200, 0, rd);
    chk(rd == pat(25'h0000200), "R1 low ignores window 63", rd, pat(25'h0000200));
  endtask

  task automatic t_wait();
    logic [31:0] rd;
    memLat = 3;
    access(0, 20'h80008, 0, rd);
    chk(rd == pat(25'h1F80008), "R8 read with wait states", rd, pat(25'h1F80008));
    access(1, 20'h00010, 32'h0BADF00D, rd);
    chk(lastAddr == 25'h10 && lastWdata == 32'h0BADF00D, "R8 write with wait states",
        lastWdata, 32'h0BADF00D);
    memLat = 0;
  endtask

  task automatic t_reenable_off();
    logic [31:0] rd;
    access(1, 20'h0310C, 32'h0000003F, rd);
    access(0, 20'h0310C, 0, rd);
    chk(rd == 32'h0000003F, "R4 readback enable clear", rd, 32'h3F);
    t_disabled("R6 after disable");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_low();
    t_disabled("R6");
    t_ctrl();
    t_high();
    t_switch();
    t_wait();
    t_reenable_off();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule